// File: doc/BRIEF.md
# Prefix-Extended Load Address Unit

This block computes the memory read address and the base-register write-back for a 16-bit load. The load's step size can be widened by up to two prefix instructions that arrive before it. Each prefix carries a 13-bit immediate. The unit keeps the pending prefixes in a small accumulator. When the load arrives, it forms a step of 2 (no prefix), a zero-extended 13-bit value (one prefix), or a 24-bit value built from both prefixes.

The load uses one of three addressing modes:
- read at the base, then add the step (post-increment);
- read at the base, then subtract the step (post-decrement);
- subtract the step first, then read at the result and write that result back (pre-decrement).

A load in a branch delay slot ignores and discards any pending prefixes.

An odd access address raises a misalignment interrupt pulse, but the read is still issued with bit 0 cleared. Read data returned by memory is zero-extended from 16 to 24 bits for the destination register. All outputs are registered and appear in the cycle after the load is accepted.

Top module: `ldx_addr_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, rd_req_o, base_wr_o, misalign_irq_o and dest_we_o are 0, and no prefix is pending.
- R2: An accepted prefix (pfx_valid_i with ld_valid_i low) is held until used. With one pending prefix the step is {11'b0, imm}. With two, the step is {first[10:0], second[12:0]}. A third prefix drops the oldest, so the latest two are kept.
- R3: Mode 2'b00 (post-increment; code 2'b11 behaves the same): rd_addr_o is the base, and base_wdata_o is base + step. The step is 2 when no prefix is pending.
- R4: Mode 2'b01 (post-decrement): rd_addr_o is the base, and base_wdata_o is base − step. The step is 2 with no prefix.
- R5: Mode 2'b10 (pre-decrement): both rd_addr_o and base_wdata_o are base − step. The step is 2 with no prefix.
- R6: All address arithmetic wraps modulo 2^24.
- R7: When slot_i is high with a load, pending prefixes are not applied (the step is 2) and are discarded. A following load without new prefixes also steps by 2.
- R8: If bit 0 of the access address is 1, misalign_irq_o pulses with the read. rd_addr_o has bit 0 forced to 0, and the write-back value is not altered.
- R9: One cycle after rdata_valid_i, dest_we_o pulses and dest_o equals {8'h00, rdata_i}.
- R10: rd_req_o and base_wr_o pulse together for exactly one cycle, the cycle after ld_valid_i is sampled high. Otherwise they stay low.
- R11: A prefix presented in the same cycle as a load is dropped. The load uses the prefixes pending before it, and afterwards none are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_valid_i | input | 1 | Prefix instruction present |
| pfx_imm_i | input | 13 | Prefix immediate |
| ld_valid_i | input | 1 | Load instruction present |
| ld_mode_i | input | 2 | 00 post-inc, 01 post-dec, 10 pre-dec, 11 as 00 |
| slot_i | input | 1 | Load sits in a branch delay slot |
| base_i | input | 24 | Current base-register value |
| rdata_valid_i | input | 1 | Memory read data valid |
| rdata_i | input | 16 | Memory read data |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 24 | Read address, bit 0 forced low |
| base_wr_o | output | 1 | Base-register write enable |
| base_wdata_o | output | 24 | New base-register value |
| misalign_irq_o | output | 1 | Address-misaligned interrupt pulse |
| dest_we_o | output | 1 | Destination write enable |
| dest_o | output | 24 | Zero-extended load data |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the misalignment interrupt and a wrapped address calculation. The bench provokes this with odd bases and odd prefix immediates, including bases near 0 and 0xFFFFFE. It judges each read by the forced-even address, the unforced write-back and the interrupt flag, all taken from an independent model.

The second pair is a prefix and a load arriving together, and a delay-slot load with prefixes pending. For these, the scoreboard checks that the load's step ignores the dropped prefix. It also checks that the next load steps by 2.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 16;
  localparam int PFX_W   = 13;
  localparam int HI_W    = ADDR_W - PFX_W;

  typedef enum logic [1:0] {
    MODE_POSTINC = 2'b00,
    MODE_POSTDEC = 2'b01,
    MODE_PREDEC  = 2'b10,
    MODE_RSVD    = 2'b11
  } ld_mode_e;
endpackage

// File: rtl/ldx_pfx_acc.sv
module ldx_pfx_acc #(
  parameter int PFX_W  = 13,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pfx_valid,
  input  logic [PFX_W-1:0]  pfx_imm,
  input  logic              consume,
  output logic [1:0]        cnt,
  output logic [ADDR_W-1:0] imm
);
  localparam int HI_W = ADDR_W - PFX_W;

  logic [PFX_W-1:0] older_q, newer_q;
  logic [1:0]       cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= 2'd0;
      older_q <= '0;
      newer_q <= '0;
    end else if (consume) begin
      cnt_q <= 2'd0;
    end else if (pfx_valid) begin
      older_q <= newer_q;
      newer_q <= pfx_imm;
      if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
    end
  end

  always_comb begin
    case (cnt_q)
      2'd1:    imm = {{HI_W{1'b0}}, newer_q};
      2'd2:    imm = {older_q[HI_W-1:0], newer_q};
      default: imm = '0;
    endcase
  end

  assign cnt = cnt_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= 2'd2);
  assert_consume_clears_R7: assert property (@(posedge clk) disable iff (rst)
    consume |=> cnt_q == 2'd0);
  assert_pfx_counts_R2: assert property (@(posedge clk) disable iff (rst)
    (pfx_valid && !consume && cnt_q == 2'd0) |=> cnt_q == 2'd1);
endmodule

// File: rtl/ldx_addr_gen.sv
module ldx_addr_gen
  import ldx_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        mode,
  input  logic [1:0]        pfx_cnt,
  input  logic [ADDR_W-1:0] pfx_imm,
  input  logic              in_slot,
  output logic [ADDR_W-1:0] access_addr,
  output logic [ADDR_W-1:0] new_base,
  output logic              odd
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] step, sum, diff;

  always_comb begin
    step = (in_slot || pfx_cnt == 2'd0) ? HALF_STEP : pfx_imm;
    sum  = base + step;
    diff = base - step;
    case (ld_mode_e'(mode))
      MODE_POSTDEC: begin access_addr = base; new_base = diff; end
      MODE_PREDEC:  begin access_addr = diff; new_base = diff; end
      default:      begin access_addr = base; new_base = sum;  end
    endcase
    odd = access_addr[0];
  end
endmodule

// File: rtl/ldx_zext.sv
module ldx_zext #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic              dest_we,
  output logic [ADDR_W-1:0] dest
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dest_we <= 1'b0;
      dest    <= '0;
    end else begin
      dest_we <= rvalid;
      if (rvalid) dest <= {{(ADDR_W-DATA_W){1'b0}}, rdata};
    end
  end

  assert_we_follows_R9: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> dest_we);
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    dest_we |-> dest[ADDR_W-1:DATA_W] == '0);
endmodule

// File: rtl/ldx_addr_unit.sv
module ldx_addr_unit
  import ldx_pkg::*;
#(
  parameter int ADDR_W = ldx_pkg::ADDR_W,
  parameter int DATA_W = ldx_pkg::DATA_W,
  parameter int PFX_W  = ldx_pkg::PFX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pfx_valid_i,
  input  logic [PFX_W-1:0]  pfx_imm_i,
  input  logic              ld_valid_i,
  input  logic [1:0]        ld_mode_i,
  input  logic              slot_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              rdata_valid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              base_wr_o,
  output logic [ADDR_W-1:0] base_wdata_o,
  output logic              misalign_irq_o,
  output logic              dest_we_o,
  output logic [ADDR_W-1:0] dest_o
);
  logic [1:0]        pfx_cnt;
  logic [ADDR_W-1:0] pfx_imm_w;
  logic [ADDR_W-1:0] acc_addr, nxt_base;
  logic              odd;

  ldx_pfx_acc #(.PFX_W(PFX_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .pfx_valid(pfx_valid_i), .pfx_imm(pfx_imm_i),
    .consume(ld_valid_i), .cnt(pfx_cnt), .imm(pfx_imm_w));

  ldx_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
    .base(base_i), .mode(ld_mode_i), .pfx_cnt(pfx_cnt), .pfx_imm(pfx_imm_w),
    .in_slot(slot_i), .access_addr(acc_addr), .new_base(nxt_base), .odd(odd));

  ldx_zext #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_zext (
    .clk(clk), .rst(rst), .rvalid(rdata_valid_i), .rdata(rdata_i),
    .dest_we(dest_we_o), .dest(dest_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o       <= 1'b0;
      base_wr_o      <= 1'b0;
      misalign_irq_o <= 1'b0;
      rd_addr_o      <= '0;
      base_wdata_o   <= '0;
    end else begin
      rd_req_o       <= ld_valid_i;
      base_wr_o      <= ld_valid_i;
      misalign_irq_o <= ld_valid_i & odd;
      if (ld_valid_i) begin
        rd_addr_o    <= {acc_addr[ADDR_W-1:1], 1'b0};
        base_wdata_o <= nxt_base;
      end
    end
  end

  assert_req_wr_pair_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req_o == base_wr_o);
  assert_req_after_load_R10: assert property (@(posedge clk) disable iff (rst)
    ld_valid_i |=> rd_req_o);
  assert_even_addr_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> !rd_addr_o[0]);
  assert_irq_with_req_R8: assert property (@(posedge clk) disable iff (rst)
    misalign_irq_o |-> rd_req_o);
endmodule

// File: tb/ldx_addr_unit_bench.sv
module ldx_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pfx_valid_i = 1'b0;
  logic [12:0] pfx_imm_i = '0;
  logic        ld_valid_i = 1'b0;
  logic [1:0]  ld_mode_i = '0;
  logic        slot_i = 1'b0;
  logic [23:0] base_i = '0;
  logic        rdata_valid_i = 1'b0;
  logic [15:0] rdata_i = '0;
  logic        rd_req_o, base_wr_o, misalign_irq_o, dest_we_o;
  logic [23:0] rd_addr_o, base_wdata_o, dest_o;

  always #10 clk = ~clk;

  ldx_addr_unit u_ldx_addr_unit (.*);

  int checks = 0, fails = 0;
  logic [48:0] exp_q[$];
  logic [23:0] dest_q[$];
  logic [12:0] m_old = '0, m_new = '0;
  int          m_cnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prefix(logic [12:0] v);
    @(negedge clk);
    pfx_valid_i = 1'b1; pfx_imm_i = v;
    @(posedge clk); #1 pfx_valid_i = 1'b0;
    m_old = m_new; m_new = v;
    if (m_cnt < 2) m_cnt++;
  endtask

  task automatic load(logic [1:0] mode, logic [23:0] base, logic slot,
                      logic with_pfx = 1'b0);
    logic [23:0] step, acc, wb;
    if (slot || m_cnt == 0) step = 24'd2;
    else if (m_cnt == 1)    step = {11'd0, m_new};
    else                    step = {m_old[10:0], m_new};
    if (mode == 2'b01)      begin acc = base;        wb = base - step; end
    else if (mode == 2'b10) begin acc = base - step; wb = base - step; end
    else                    begin acc = base;        wb = base + step; end
    exp_q.push_back({acc[0], acc & 24'hFFFFFE, wb});
    m_cnt = 0;
    @(negedge clk);
    ld_valid_i = 1'b1; ld_mode_i = mode; base_i = base; slot_i = slot;
    pfx_valid_i = with_pfx; pfx_imm_i = 13'h1FFF;
    @(posedge clk); #1 ld_valid_i = 1'b0; slot_i = 1'b0; pfx_valid_i = 1'b0;
  endtask

  task automatic rdata(logic [15:0] d);
    dest_q.push_back({8'h00, d});
    @(negedge clk);
    rdata_valid_i = 1'b1; rdata_i = d;
    @(posedge clk); #1 rdata_valid_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_req_o) begin
        if (exp_q.size() == 0) check("R10 unexpected read", 1, 0);
        else begin
          logic [48:0] e;
          e = exp_q.pop_front();
          check("R3/R4/R5/R6 rd_addr (R8 even)", {8'h0, rd_addr_o}, {8'h0, e[47:24]});
          check("R3/R4/R5/R6/R7 base_wdata", {8'h0, base_wdata_o}, {8'h0, e[23:0]});
          check("R8 misalign_irq", {31'h0, misalign_irq_o}, {31'h0, e[48]});
          check("R10 base_wr with rd_req", {31'h0, base_wr_o}, 1);
        end
      end else if (base_wr_o || misalign_irq_o) check("R10 stray write/irq", 1, 0);
      if (dest_we_o) begin
        if (dest_q.size() == 0) check("R9 unexpected dest_we", 1, 0);
        else check("R9 dest zero-extend", {8'h0, dest_o}, {8'h0, dest_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset outputs", {28'h0, rd_req_o, base_wr_o, misalign_irq_o, dest_we_o}, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {28'h0, rd_req_o, base_wr_o, misalign_irq_o, dest_we_o}, 0);
    load(2'b00, 24'h000100, 0);                         // R3 no prefix
    load(2'b01, 24'h000300, 0);                         // R4 no prefix
    load(2'b10, 24'h000400, 0);                         // R5 no prefix
    prefix(13'h0010); load(2'b01, 24'h000200, 0);       // R4 one prefix
    prefix(13'h0ABC); load(2'b00, 24'h001000, 0);       // R3 one prefix
    prefix(13'h0020); load(2'b10, 24'h008000, 0);       // R5 one prefix
    prefix(13'h1805); prefix(13'h0004); load(2'b10, 24'h100000, 0); // R2 R5
    prefix(13'h0003); prefix(13'h1FF0); load(2'b00, 24'h010000, 0); // R2 R3
    prefix(13'h07FF); prefix(13'h1FFE); load(2'b01, 24'hF00000, 0); // R2 R4
    prefix(13'h0001); prefix(13'h0002); prefix(13'h0004);
    load(2'b00, 24'h000000, 0);                         // R2 third prefix
    load(2'b00, 24'h000101, 0);                         // R8 odd base
    prefix(13'h0003); load(2'b10, 24'h000200, 0);       // R8 odd via pre-dec
    load(2'b00, 24'hFFFFFE, 0);                         // R6 wrap up
    load(2'b10, 24'h000000, 0);                         // R6 wrap down
    prefix(13'h0100); load(2'b01, 24'h000010, 0);       // R6 R4 wrap
    prefix(13'h0200); prefix(13'h0300); load(2'b00, 24'h002000, 1); // R7
    load(2'b00, 24'h002000, 0);                         // R7 pending discarded
    prefix(13'h0040); load(2'b00, 24'h003000, 0, 1);    // R11 same-cycle prefix
    load(2'b01, 24'h003000, 0);                         // R11 dropped prefix
    load(2'b11, 24'h004000, 0);                         // R3 reserved mode
    load(2'b00, 24'h005000, 0); load(2'b10, 24'h005001, 0); // R10 back-to-back
    rdata(16'hBEEF); rdata(16'h8001);                   // R9
    repeat (4) @(negedge clk);
    check("R10 scoreboard drained", exp_q.size() + dest_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule